// File: doc/BRIEF.md
# Double-Edge Strobed Burst Word Sender

This block is the sending side of a 16-bit parallel burst in which every change of the strobe line, rising or falling, hands one word across. It takes words from a ready/valid style source: the head word is presented on `src_data` while `src_valid` is high, and `src_pop` removes it. It places each word on `bus_data`, waits out a programmable data-setup interval, then toggles `strobe`. Before the next word may replace it on the bus, the word is held for a programmable hold interval. Successive strobe changes are kept at least one programmed cycle period apart.

Software, or a controlling state machine, presents the setup, hold and cycle counts and a word total, then pulses `start`. The block copies these values at that point and ignores later changes until the burst is over. The receiver can pause the burst by dropping `host_ready`. Strobing stops within a fixed number of clock edges set by the depth of the ready synchronizer, and resumes when ready returns. The strobe level is carried through a pause, so the first word after resume is marked by the opposite transition. When the programmed total has been sent and the last word has been held, `busy` falls and `done` rises.

Top module: `edge_burst_tx`

## Requirements
- R1: After reset `strobe`, `bus_data`, `src_pop`, `busy` and `done` are all 0.
- R2: A strobe transition happens at least max(t_setup,1) clock edges after the last change of `bus_data`. `bus_data` never changes on the same edge as `strobe`.
- R3: `bus_data` changes at least max(t_hold,1) clock edges after the last strobe transition.
- R4: Two consecutive strobe transitions are at least max(t_cycle,1) clock edges apart.
- R5: Two transitions of the same polarity are at least 2*t_cycle clock edges apart.
- R6: `src_pop` is high, with `src_valid` high, in exactly those cycles that are followed by a strobe transition. At each transition the value on `bus_data` is the source head word that was popped, and words go out in source order.
- R7: A burst of word_total N makes exactly N transitions and N pops. `done` rises at least max(t_hold,1) edges after the last transition, with `busy` low, and stays high until the next accepted `start`. N = 0 gives `done` with no transition.
- R8: While `host_ready` is low there is no pop, and no strobe transition later than SYNC_STAGES clock edges after the first edge that samples it low.
- R9: After a pause the strobe keeps its level. When `host_ready` returns, the burst continues with the next word, marked by the opposite transition, and no word is lost.
- R10: A `start` pulse while `busy` is high has no effect on the running burst's word count.
- R11: t_setup, t_hold, t_cycle and word_total are sampled only at an accepted `start`. Changing them while busy does not change the spacing of the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a burst; accepted only while idle |
| word_total | input | LEN_W | Number of words in the burst |
| t_setup | input | CNT_W | Minimum edges from a bus change to a strobe transition |
| t_hold | input | CNT_W | Minimum edges from a strobe transition to a bus change |
| t_cycle | input | CNT_W | Minimum edges between strobe transitions |
| src_data | input | DATA_W | Head word of the source |
| src_valid | input | 1 | Source head word is present |
| src_pop | output | 1 | Remove head word; the transfer edge follows |
| host_ready | input | 1 | Receiver ready; low pauses the burst |
| bus_data | output | DATA_W | Parallel data bus |
| strobe | output | 1 | Word strobe; every transition carries a word |
| busy | output | 1 | A burst is in progress |
| done | output | 1 | Last burst completed |

## Verification
A stale loaded flag or a wrong age counter shows up at the next word. The bus changes too soon after a transition, or the strobe moves before the setup count has run out, and the edge-spacing checks catch this at that very transition. A word counter that is off by one is seen at the end of the burst, either as an extra or missing pop against the source pointer or as `done` arriving early. A pause path that does not gate shows a strobe transition more than SYNC_STAGES edges after ready dropped. Because the receiver compares every word captured at a transition with the expected source order, any slip between pop and strobe shows up at the first word after the slip.

// File: rtl/ebt_pkg.sv
package ebt_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SEND  = 2'd1,
      ST_DRAIN = 2'd2
   } ebt_state_e;

endpackage

// File: rtl/ebt_rdy_sync.sv
module ebt_rdy_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   if (STAGES < 0 || STAGES > 4) begin : g_bad_depth
      $error("ebt_rdy_sync: STAGES must lie in 0..4");
   end

   if (STAGES == 0) begin : g_direct
      assign sync_out = async_in;
   end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
         end else begin
            chain_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
               chain_q[i] <= chain_q[i-1];
            end
         end
      end
      assign sync_out = chain_q[STAGES-1];
   end

endmodule

// File: rtl/ebt_age_ctr.sv
module ebt_age_ctr #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         mark,
   input  logic         fill,
   output logic [W-1:0] age
);

   localparam logic [W-1:0] SAT = '1;
   localparam logic [W-1:0] ONE = W'(1);

   if (W < 2) begin : g_bad_width
      $error("ebt_age_ctr: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age <= SAT;
      end else if (fill) begin
         age <= SAT;
      end else if (mark) begin
         age <= ONE;
      end else if (age != SAT) begin
         age <= age + ONE;
      end
   end

endmodule

// File: rtl/ebt_word_ctr.sv
module ebt_word_ctr #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] left,
   output logic         last
);

   localparam logic [W-1:0] ONE = W'(1);

   if (W < 1) begin : g_bad_width
      $error("ebt_word_ctr: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left <= '0;
      end else if (load) begin
         left <= load_val;
      end else if (dec && left != '0) begin
         left <= left - ONE;
      end
   end

   assign last = (left == ONE);

endmodule

// File: rtl/edge_burst_tx.sv
module edge_burst_tx
   import ebt_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 6,
   parameter int LEN_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LEN_W-1:0]  word_total,
   input  logic [CNT_W-1:0]  t_setup,
   input  logic [CNT_W-1:0]  t_hold,
   input  logic [CNT_W-1:0]  t_cycle,
   input  logic [DATA_W-1:0] src_data,
   input  logic              src_valid,
   output logic              src_pop,
   input  logic              host_ready,
   output logic [DATA_W-1:0] bus_data,
   output logic              strobe,
   output logic              busy,
   output logic              done
);

   localparam int AGE_W = CNT_W + 1;

   if (DATA_W < 1) begin : g_bad_data
      $error("edge_burst_tx: DATA_W must be at least 1");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("edge_burst_tx: CNT_W must lie in 1..16");
   end
   if (LEN_W < 1 || LEN_W > 31) begin : g_bad_len
      $error("edge_burst_tx: LEN_W must lie in 1..31");
   end

   ebt_state_e        state_q;
   logic [CNT_W-1:0]  setup_q, hold_q, cycle_q;
   logic              loaded_q;
   logic [DATA_W-1:0] bus_q;
   logic              strobe_q;
   logic              done_q;

   logic              rdy_s;
   logic [AGE_W-1:0]  data_age, edge_age;
   logic [LEN_W-1:0]  words_left;
   logic              last_word;

   logic accept, zero_len, sending, load_word, fire, hold_met;

   assign accept    = start && (state_q == ST_IDLE);
   assign zero_len  = (word_total == '0);
   assign sending   = (state_q == ST_SEND);
   assign hold_met  = (edge_age >= AGE_W'(hold_q));
   assign load_word = sending && !loaded_q && src_valid && hold_met;
   assign fire      = sending && loaded_q && src_valid && rdy_s
                      && (data_age >= AGE_W'(setup_q))
                      && (edge_age >= AGE_W'(cycle_q));

   ebt_rdy_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (host_ready),
      .sync_out (rdy_s)
   );

   ebt_age_ctr #(.W(AGE_W)) u_data_age (
      .clk   (clk),
      .rst_n (rst_n),
      .mark  (load_word),
      .fill  (accept),
      .age   (data_age)
   );

   ebt_age_ctr #(.W(AGE_W)) u_edge_age (
      .clk   (clk),
      .rst_n (rst_n),
      .mark  (fire),
      .fill  (accept),
      .age   (edge_age)
   );

   ebt_word_ctr #(.W(LEN_W)) u_word_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (word_total),
      .dec      (fire),
      .left     (words_left),
      .last     (last_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setup_q <= '0;
         hold_q  <= '0;
         cycle_q <= '0;
      end else if (accept) begin
         setup_q <= t_setup;
         hold_q  <= t_hold;
         cycle_q <= t_cycle;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_q    <= '0;
         loaded_q <= 1'b0;
         strobe_q <= 1'b0;
      end else begin
         if (load_word) begin
            bus_q    <= src_data;
            loaded_q <= 1'b1;
         end else if (fire) begin
            loaded_q <= 1'b0;
            strobe_q <= ~strobe_q;
         end else if (accept) begin
            loaded_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  done_q  <= zero_len;
                  state_q <= zero_len ? ST_IDLE : ST_SEND;
               end
            end
            ST_SEND: begin
               if (fire && last_word) begin
                  state_q <= ST_DRAIN;
               end
            end
            ST_DRAIN: begin
               if (hold_met) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign src_pop  = fire;
   assign bus_data = bus_q;
   assign strobe   = strobe_q;
   assign busy     = (state_q != ST_IDLE);
   assign done     = done_q;

endmodule

// File: rtl/ebt_chk.sv
module ebt_chk #(
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 6,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [CNT_W-1:0]  t_setup,
   input logic [CNT_W-1:0]  t_hold,
   input logic [CNT_W-1:0]  t_cycle,
   input logic              src_valid,
   input logic              src_pop,
   input logic              host_ready,
   input logic [DATA_W-1:0] bus_data,
   input logic              strobe,
   input logic              busy,
   input logic              done
);

   localparam int unsigned CAP = 32'd1 << 24;

   function automatic int unsigned bump(input int unsigned v);
      return (v >= CAP) ? CAP : v + 1;
   endfunction

   logic [DATA_W-1:0] bus_p;
   logic              str_p;
   int unsigned       dc, ec, pc, lowc;
   int unsigned       c_setup, c_hold, c_cycle;
   logic              schg, dchg;

   assign schg = (strobe != str_p);
   assign dchg = (bus_data != bus_p);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_p   <= '0;
         str_p   <= 1'b0;
         dc      <= CAP;
         ec      <= CAP;
         pc      <= CAP;
         lowc    <= 0;
         c_setup <= 0;
         c_hold  <= 0;
         c_cycle <= 0;
      end else begin
         bus_p <= bus_data;
         str_p <= strobe;
         dc    <= dchg ? 1 : bump(dc);
         ec    <= schg ? 1 : bump(ec);
         pc    <= schg ? bump(ec) : bump(pc);
         lowc  <= host_ready ? 0 : bump(lowc);
         if (start && !busy) begin
            c_setup <= int'(t_setup);
            c_hold  <= int'(t_hold);
            c_cycle <= int'(t_cycle);
         end
      end
   end

   a_r2_setup_met: assert property (@(posedge clk) disable iff (!rst_n)
      schg |-> dc >= c_setup);
   a_r2_no_shared_edge: assert property (@(posedge clk) disable iff (!rst_n)
      schg |-> !dchg);
   a_r3_hold_met: assert property (@(posedge clk) disable iff (!rst_n)
      dchg |-> ec >= c_hold);
   a_r4_cycle_gap: assert property (@(posedge clk) disable iff (!rst_n)
      schg |-> ec >= c_cycle);
   a_r5_same_polarity: assert property (@(posedge clk) disable iff (!rst_n)
      schg |-> pc >= 2 * c_cycle);
   a_r6_pop_then_edge: assert property (@(posedge clk) disable iff (!rst_n)
      src_pop |=> strobe != $past(strobe));
   a_r6_edge_had_pop: assert property (@(posedge clk) disable iff (!rst_n)
      schg |-> $past(src_pop));
   a_r6_pop_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      src_pop |-> src_valid);
   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   a_r8_pause_stop: assert property (@(posedge clk) disable iff (!rst_n)
      schg |-> lowc <= SYNC_STAGES);

endmodule

bind edge_burst_tx ebt_chk #(
   .DATA_W      (DATA_W),
   .CNT_W       (CNT_W),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .t_setup    (t_setup),
   .t_hold     (t_hold),
   .t_cycle    (t_cycle),
   .src_valid  (src_valid),
   .src_pop    (src_pop),
   .host_ready (host_ready),
   .bus_data   (bus_data),
   .strobe     (strobe),
   .busy       (busy),
   .done       (done)
);

// File: tb/test_edge_burst_tx.sv
`timescale 1ns/1ps
module test_edge_burst_tx;

   localparam int DW = 16;
   localparam int CW = 6;
   localparam int LW = 16;
   localparam int SS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [LW-1:0] word_total = '0;
   logic [CW-1:0] t_setup = '0, t_hold = '0, t_cycle = '0;
   logic [DW-1:0] src_data;
   logic          src_valid;
   logic          src_pop;
   logic          host_ready = 1'b1;
   logic [DW-1:0] bus_data;
   logic          strobe, busy, done;

   edge_burst_tx #(.DATA_W(DW), .CNT_W(CW), .LEN_W(LW), .SYNC_STAGES(SS)) i_edge_burst_tx (
      .clk(clk), .rst_n(rst_n), .start(start), .word_total(word_total),
      .t_setup(t_setup), .t_hold(t_hold), .t_cycle(t_cycle),
      .src_data(src_data), .src_valid(src_valid), .src_pop(src_pop),
      .host_ready(host_ready), .bus_data(bus_data), .strobe(strobe),
      .busy(busy), .done(done)
   );

   always #2 clk = ~clk;   // 250 MHz

   int checks = 0, fails = 0;
   logic [DW-1:0] mem [0:63];
   int ptr = 0, avail = 0, rx_idx = 0;
   logic gate = 1'b1;
   int cyc = 0, low_cyc = -1;
   int last_bus = -1000, last_str = -1000, prev_str = -1000;
   int b_setup = 0, b_hold = 0, b_cycle = 0, b_total = 0;
   logic pend = 1'b0, str_prev = 1'b0, done_prev = 1'b0;
   logic [DW-1:0] bus_prev = '0;
   logic mon_on = 1'b0;

   assign src_valid = gate && (ptr < avail);
   assign src_data  = mem[ptr[5:0]];

   function automatic int at_least1(input int v);
      return (v < 1) ? 1 : v;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Monitor: samples 1ns after each rising edge; cyc numbers edges.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         cyc++;
         if (pend) ptr++;
         if (mon_on) begin
            if (strobe != str_prev) begin
               chk(pend, "R6 transition without pop", 0, 1);
               chk(cyc - last_bus >= at_least1(b_setup), "R2 setup", cyc - last_bus, at_least1(b_setup));
               chk(bus_data == bus_prev, "R2 bus moved with strobe", int'(bus_data), int'(bus_prev));
               chk(cyc - last_str >= at_least1(b_cycle), "R4 cycle gap", cyc - last_str, at_least1(b_cycle));
               chk(cyc - prev_str >= 2 * b_cycle, "R5 same polarity gap", cyc - prev_str, 2 * b_cycle);
               chk(bus_data == mem[rx_idx[5:0]], "R6 word order", int'(bus_data), int'(mem[rx_idx[5:0]]));
               if (!host_ready && low_cyc >= 0)
                  chk(cyc - low_cyc <= SS, "R8 strobe after pause", cyc - low_cyc, SS);
               rx_idx++;
               prev_str = last_str;
               last_str = cyc;
            end else if (pend) begin
               chk(1'b0, "R6 pop without transition", 0, 1);
            end
            if (bus_data != bus_prev) begin
               chk(cyc - last_str >= at_least1(b_hold), "R3 hold", cyc - last_str, at_least1(b_hold));
               last_bus = cyc;
            end
            if (done && !done_prev && b_total > 0)
               chk(cyc - last_str >= at_least1(b_hold), "R7 done after hold", cyc - last_str, at_least1(b_hold));
         end
         str_prev  = strobe;
         bus_prev  = bus_data;
         done_prev = done;
         #2;
         pend = src_pop;
      end
   end

   initial begin
      #(4ns * 150000);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   task automatic step();
      @(negedge clk);
   endtask

   task automatic set_ready(input logic v);
      host_ready = v;
      low_cyc = v ? -1 : cyc;
   endtask

   // Runs one burst; mode bit0 random valid/ready, bit1 pause, bit2 pokes while busy.
   task automatic run_burst(input int total, input int su, input int ho, input int cy, input int mode);
      int held_ptr;
      logic held_str;
      step();
      for (int i = 0; i < 64; i++) mem[i] = DW'($urandom);
      ptr = 0; rx_idx = 0; avail = total + 2; gate = 1'b1;
      b_setup = su; b_hold = ho; b_cycle = cy; b_total = total;
      last_str = -1000; prev_str = -1000; last_bus = -1000;
      word_total = LW'(total);
      t_setup = CW'(su); t_hold = CW'(ho); t_cycle = CW'(cy);
      start = 1'b1;
      step();
      start = 1'b0;
      for (int n = 0; n < 4000 && !done; n++) begin
         if (mode[2] && n == 3) begin
            word_total = LW'(total + 5);
            t_setup = '0; t_hold = '0; t_cycle = '0;
            start = 1'b1;                      // R10 / R11 poke while busy
         end else begin
            start = 1'b0;
         end
         if (mode[1] && rx_idx >= 5 && host_ready && low_cyc == -1 && n < 2000) begin
            set_ready(1'b0);
            for (int k = 0; k < SS + 2; k++) step();
            held_ptr = ptr;
            held_str = strobe;
            for (int k = 0; k < 30; k++) step();
            chk(ptr == held_ptr, "R8 no pop while paused", ptr, held_ptr);
            chk(strobe == held_str, "R8 strobe frozen while paused", int'(strobe), int'(held_str));
            set_ready(1'b1);
            low_cyc = -2;
            while (strobe == held_str && !done) step();
            chk(strobe == !held_str, "R9 resume with opposite transition", int'(strobe), int'(!held_str));
         end
         if (mode[0]) begin
            gate = ($urandom % 4) != 0;
            if (($urandom % 8) == 0) set_ready(!host_ready);
         end
         step();
      end
      start = 1'b0; gate = 1'b1;
      if (!host_ready) set_ready(1'b1);
      low_cyc = -1;
      for (int k = 0; k < 8; k++) step();
      chk(done == 1'b1, "R7 done raised", int'(done), 1);
      chk(busy == 1'b0, "R7 busy cleared", int'(busy), 0);
      chk(rx_idx == total, "R7 transitions per burst", rx_idx, total);
      chk(ptr == total, "R7 pops per burst", ptr, total);
   endtask

   initial begin
      repeat (3) step();
      chk(strobe == 1'b0, "R1 strobe reset", int'(strobe), 0);
      chk(bus_data == '0, "R1 bus reset", int'(bus_data), 0);
      chk(src_pop == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 control reset",
          int'({src_pop, busy, done}), 0);
      rst_n = 1'b1;
      step();
      mon_on = 1'b1;
      void'($urandom(32'd20240611));

      run_burst(8, 2, 1, 3, 0);
      for (int k = 0; k < 20; k++) step();
      chk(done == 1'b1, "R7 done held while idle", int'(done), 1);
      run_burst(0, 1, 1, 1, 0);
      run_burst(10, 0, 0, 0, 0);
      run_burst(20, 1, 2, 2, 2);
      run_burst(12, 3, 2, 4, 4);
      run_burst(1, 5, 5, 5, 0);
      for (int b = 0; b < 8; b++)
         run_burst(int'($urandom % 16), int'($urandom % 6), int'($urandom % 6), int'($urandom % 6), 1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule